// File: doc/BRIEF.md
# Set-Associative Translation Buffer

This block is a small on-chip cache of page table entries. A lookup presents an 8-bit virtual page number. One cycle later the block reports whether a valid cached entry matches. On a hit it also returns that entry's physical page number and permission bits. A hit means the translation completes without reading the entry from memory. On a miss, an external page walker makes one extra memory access to fetch the entry and then installs it through the fill port.

Storage is 16 entries, organised as 4 sets of 4 ways. The low bits of the virtual page number pick the set and the remaining upper bits form the tag. A fill of a tag that is already present refreshes that way in place. Otherwise the fill takes a free way, and when the set is full it evicts the way named by that set's rotating pointer. A one-cycle flush empties the whole buffer, for use on an address-space switch.

Top module: `tlb_sa`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and `resp_valid_o` and `resp_hit_o` are 0.
- R2: A lookup accepted with `lookup_i`=1 in cycle N produces `resp_valid_o`=1 in cycle N+1 only. `resp_valid_o` is 0 in every cycle that follows a cycle without a lookup.
- R3: The set index is `vpn[1:0]` and the tag is `vpn[7:2]`. For example, VPN 0x0F maps to set 3, tag 0x03; VPN 0x2E maps to set 2, tag 0x0B; VPN 0x00 maps to set 0, tag 0x00. An entry installed for one VPN never hits for a VPN that differs in either field.
- R4: A hit requires a valid entry in the indexed set whose tag matches. On a hit the response carries that entry's 6-bit PPN and 3-bit permission field.
- R5: On a miss, `resp_ppn_o` and `resp_perm_o` are 0.
- R6: A fill whose tag is absent from its set goes into the lowest-numbered invalid way, so up to 4 distinct tags in one set all stay resident.
- R7: When the set is full, a fill evicts the way selected by that set's pointer. The pointer starts at way 0 and advances by one, modulo 4, on each such eviction.
- R8: A fill whose tag is already valid in the set overwrites that way, and later lookups return the new PPN and permissions.
- R9: `flush_i` invalidates all 16 entries in one cycle.
- R10: When `flush_i` and `fill_i` are high in the same cycle, the flush wins and the fill is dropped.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill. The filled entry is visible to lookups from the next cycle on.
- R12: Fills and evictions in one set leave the entries of the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Lookup request strobe |
| lookup_vpn_i | input | 8 | Virtual page number to translate |
| resp_valid_o | output | 1 | Response for the previous cycle's lookup |
| resp_hit_o | output | 1 | Matching valid entry found |
| resp_ppn_o | output | 6 | Physical page number on a hit, 0 on a miss |
| resp_perm_o | output | 3 | Permission bits on a hit, 0 on a miss |
| fill_i | input | 1 | Install an entry supplied by the walker |
| fill_vpn_i | input | 8 | Virtual page number of the entry to install |
| fill_ppn_i | input | 6 | Physical page number of the entry to install |
| fill_perm_i | input | 3 | Permission bits of the entry to install |
| flush_i | input | 1 | Invalidate all entries |

## Verification
A wrong valid bit, tag or replacement pointer inside the block shows up only at the next lookup that indexes the affected set. That lookup returns a stale hit, a missing hit or the wrong PPN one cycle after the request. Eviction order is therefore probed by overfilling one set and then looking up every tag that went in, which exposes a pointer error on the first lookup after the wrong way is replaced. Flush and fill races are checked by a lookup placed in the very next cycle, so a stale entry is reported within two cycles of the event that should have removed it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_VPN_W  = 8;
  localparam int unsigned DEF_PPN_W  = 6;
  localparam int unsigned DEF_PERM_W = 3;
  localparam int unsigned DEF_SETS   = 4;
  localparam int unsigned DEF_WAYS   = 4;

  typedef enum logic [1:0] {
    FILL_REFRESH = 2'd0,  // tag already present
    FILL_FREE    = 2'd1,  // invalid way available
    FILL_EVICT   = 2'd2   // set full, rotating pointer
  } fill_kind_e;
endpackage

// File: rtl/tlb_set_match.sv
module tlb_set_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld_i[w] && (tag_i[w] == key_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic             match_i,
  input  logic [WAY_W-1:0] match_way_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output fill_kind_e       kind_o
);
  logic             free_any;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (match_i) begin
      way_o  = match_way_i;
      kind_o = FILL_REFRESH;
    end else if (free_any) begin
      way_o  = free_way;
      kind_o = FILL_FREE;
    end else begin
      way_o  = rr_i;
      kind_o = FILL_EVICT;
    end
  end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W  = DEF_VPN_W,
  parameter int unsigned PPN_W  = DEF_PPN_W,
  parameter int unsigned PERM_W = DEF_PERM_W,
  parameter int unsigned SETS   = DEF_SETS,
  parameter int unsigned WAYS   = DEF_WAYS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [PPN_W-1:0]  resp_ppn_o,
  output logic [PERM_W-1:0] resp_perm_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              flush_i
);
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // flattened views of per-entry storage
  wire [SETS-1:0][WAYS-1:0]             vld_all;
  wire [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_all;
  wire [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_all;
  wire [SETS-1:0][WAYS-1:0][PERM_W-1:0] perm_all;
  wire [SETS-1:0][WAY_W-1:0]            rr_all;

  // lookup side
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;

  assign lk_idx = lookup_vpn_i[IDX_W-1:0];
  assign lk_tag = lookup_vpn_i[VPN_W-1:IDX_W];

  tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lk_match (
    .vld_i (vld_all[lk_idx]),
    .tag_i (tag_all[lk_idx]),
    .key_i (lk_tag),
    .hit_o (lk_hit),
    .way_o (lk_way)
  );

  // fill side
  logic [IDX_W-1:0] fl_idx;
  logic [TAG_W-1:0] fl_tag;
  logic             fl_match;
  logic [WAY_W-1:0] fl_match_way;
  logic [WAY_W-1:0] fl_way;
  fill_kind_e       fl_kind;
  logic             fl_go;

  assign fl_idx = fill_vpn_i[IDX_W-1:0];
  assign fl_tag = fill_vpn_i[VPN_W-1:IDX_W];
  assign fl_go  = fill_i && !flush_i;

  tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_fl_match (
    .vld_i (vld_all[fl_idx]),
    .tag_i (tag_all[fl_idx]),
    .key_i (fl_tag),
    .hit_o (fl_match),
    .way_o (fl_match_way)
  );

  tlb_victim_sel #(.WAYS(WAYS)) i_victim (
    .vld_i       (vld_all[fl_idx]),
    .match_i     (fl_match),
    .match_way_i (fl_match_way),
    .rr_i        (rr_all[fl_idx]),
    .way_o       (fl_way),
    .kind_o      (fl_kind)
  );

  // storage
  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             set_sel;
    logic [WAY_W-1:0] rr_q;

    assign set_sel = fl_go && (fl_idx == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rr_q <= '0;
      end else if (set_sel && fl_kind == FILL_EVICT) begin
        rr_q <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
      end
    end
    assign rr_all[s] = rr_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic              vld_q;
      logic [TAG_W-1:0]  tag_q;
      logic [PPN_W-1:0]  ppn_q;
      logic [PERM_W-1:0] perm_q;
      logic              wr_en;

      assign wr_en = set_sel && (fl_way == WAY_W'(w));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q <= 1'b0;
        end else if (flush_i) begin
          vld_q <= 1'b0;
        end else if (wr_en) begin
          vld_q <= 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tag_q  <= '0;
          ppn_q  <= '0;
          perm_q <= '0;
        end else if (wr_en) begin
          tag_q  <= fl_tag;
          ppn_q  <= fill_ppn_i;
          perm_q <= fill_perm_i;
        end
      end

      assign vld_all[s][w]  = vld_q;
      assign tag_all[s][w]  = tag_q;
      assign ppn_all[s][w]  = ppn_q;
      assign perm_all[s][w] = perm_q;
    end
  end

  // registered response
  logic              rsp_hit_d;
  logic [PPN_W-1:0]  rsp_ppn_d;
  logic [PERM_W-1:0] rsp_perm_d;

  always_comb begin
    rsp_hit_d  = lookup_i && lk_hit;
    rsp_ppn_d  = rsp_hit_d ? ppn_all[lk_idx][lk_way]  : '0;
    rsp_perm_d = rsp_hit_d ? perm_all[lk_idx][lk_way] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_ppn_o   <= '0;
      resp_perm_o  <= '0;
    end else begin
      resp_valid_o <= lookup_i;
      resp_hit_o   <= rsp_hit_d;
      resp_ppn_o   <= rsp_ppn_d;
      resp_perm_o  <= rsp_perm_d;
    end
  end
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk #(
  parameter int unsigned VPN_W  = 8,
  parameter int unsigned PPN_W  = 6,
  parameter int unsigned PERM_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_i,
  input logic [VPN_W-1:0]  lookup_vpn_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic [PPN_W-1:0]  resp_ppn_o,
  input logic [PERM_W-1:0] resp_perm_o,
  input logic              fill_i,
  input logic [VPN_W-1:0]  fill_vpn_i,
  input logic [PPN_W-1:0]  fill_ppn_i,
  input logic [PERM_W-1:0] fill_perm_i,
  input logic              flush_i
);
  p_resp_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> resp_valid_o);

  p_no_resp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> !resp_valid_o);

  p_hit_needs_resp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> resp_valid_o);

  p_miss_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> (resp_ppn_o == '0 && resp_perm_o == '0));

  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i ##1 lookup_i) |=> !resp_hit_o);

  p_fill_visible_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fill_i && !flush_i) ##1 (lookup_i && lookup_vpn_i == $past(fill_vpn_i)))
    |=> (resp_hit_o && resp_ppn_o == $past(fill_ppn_i, 2)
         && resp_perm_o == $past(fill_perm_i, 2)));
endmodule

bind tlb_sa tlb_sa_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) i_tlb_sa_chk (.*);

// File: tb/test_tlb_sa.sv
module test_tlb_sa;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lookup_i = 1'b0;
  logic [7:0] lookup_vpn_i = '0;
  logic       resp_valid_o, resp_hit_o;
  logic [5:0] resp_ppn_o;
  logic [2:0] resp_perm_o;
  logic       fill_i = 1'b0;
  logic [7:0] fill_vpn_i = '0;
  logic [5:0] fill_ppn_i = '0;
  logic [2:0] fill_perm_i = '0;
  logic       flush_i = 1'b0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  tlb_sa i_tlb_sa (
    .clk_i, .rst_ni, .lookup_i, .lookup_vpn_i,
    .resp_valid_o, .resp_hit_o, .resp_ppn_o, .resp_perm_o,
    .fill_i, .fill_vpn_i, .fill_ppn_i, .fill_perm_i, .flush_i
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one-cycle lookup; samples the response on the following falling edge
  task automatic look(input logic [7:0] vpn, output logic v, output logic h,
                      output logic [5:0] p, output logic [2:0] pm);
    @(negedge clk_i);
    lookup_i = 1'b1; lookup_vpn_i = vpn;
    @(negedge clk_i);
    lookup_i = 1'b0;
    v = resp_valid_o; h = resp_hit_o; p = resp_ppn_o; pm = resp_perm_o;
  endtask

  task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn, input logic [2:0] perm);
    @(negedge clk_i);
    fill_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_perm_i = perm;
    @(negedge clk_i);
    fill_i = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [7:0] vpn,
                            input logic [5:0] ppn, input logic [2:0] perm);
    logic v, h; logic [5:0] p; logic [2:0] pm;
    look(vpn, v, h, p, pm);
    chk(req, $sformatf("hit vpn %02h", vpn), int'(h), 1);
    chk(req, $sformatf("ppn vpn %02h", vpn), int'(p), int'(ppn));
    chk(req, $sformatf("perm vpn %02h", vpn), int'(pm), int'(perm));
  endtask

  task automatic expect_miss(input string req, input logic [7:0] vpn);
    logic v, h; logic [5:0] p; logic [2:0] pm;
    look(vpn, v, h, p, pm);
    chk(req, $sformatf("miss vpn %02h", vpn), int'(h), 0);
    chk("R5", $sformatf("zero ppn/perm vpn %02h", vpn), int'({p, pm}), 0);
  endtask

  task automatic t_reset;
    chk("R1", "resp_valid after reset", int'(resp_valid_o), 0);
    chk("R1", "resp_hit after reset", int'(resp_hit_o), 0);
    expect_miss("R1", 8'h00);
    expect_miss("R1", 8'h2E);
    expect_miss("R1", 8'h0F);
  endtask

  task automatic t_latency;
    logic v, h; logic [5:0] p; logic [2:0] pm;
    look(8'h0F, v, h, p, pm);
    chk("R2", "resp_valid one cycle after lookup", int'(v), 1);
    @(negedge clk_i);
    chk("R2", "resp_valid after idle cycle", int'(resp_valid_o), 0);
  endtask

  task automatic t_basic;
    fill(8'h0F, 6'h0D, 3'b101);          // set 3, tag 0x03
    expect_hit("R4", 8'h0F, 6'h0D, 3'b101);
    expect_miss("R3", 8'h0C);            // same tag, set 0
    expect_miss("R3", 8'h8F);            // same set, tag 0x23
    expect_miss("R3", 8'h2E);            // set 2, tag 0x0B
    expect_miss("R3", 8'h00);
  endtask

  task automatic t_fill_free;
    for (int i = 0; i < 4; i++) fill(8'(i * 4), 6'(8'h10 + i), 3'(i));
    for (int i = 0; i < 4; i++) expect_hit("R6", 8'(i * 4), 6'(8'h10 + i), 3'(i));
    expect_hit("R12", 8'h0F, 6'h0D, 3'b101);
  endtask

  task automatic t_evict;
    fill(8'h10, 6'h14, 3'd1);            // evicts way 0 (vpn 0x00)
    expect_miss("R7", 8'h00);
    expect_hit("R7", 8'h10, 6'h14, 3'd1);
    expect_hit("R7", 8'h04, 6'h11, 3'd1);
    fill(8'h14, 6'h15, 3'd2);            // evicts way 1 (vpn 0x04)
    expect_miss("R7", 8'h04);
    expect_hit("R7", 8'h08, 6'h12, 3'd2);
    expect_hit("R7", 8'h14, 6'h15, 3'd2);
    expect_hit("R12", 8'h0F, 6'h0D, 3'b101);
  endtask

  task automatic t_refresh;
    fill(8'h0F, 6'h22, 3'b010);
    expect_hit("R8", 8'h0F, 6'h22, 3'b010);
    fill(8'h03, 6'h23, 3'd3);
    fill(8'h07, 6'h24, 3'd4);
    fill(8'h0B, 6'h25, 3'd5);
    expect_hit("R8", 8'h0F, 6'h22, 3'b010);
    expect_hit("R8", 8'h03, 6'h23, 3'd3);
    expect_hit("R8", 8'h0B, 6'h25, 3'd5);
  endtask

  task automatic t_same_cycle;
    @(negedge clk_i);
    lookup_i = 1'b1; lookup_vpn_i = 8'h21;
    fill_i = 1'b1; fill_vpn_i = 8'h21; fill_ppn_i = 6'h30; fill_perm_i = 3'd6;
    @(negedge clk_i);
    lookup_i = 1'b0; fill_i = 1'b0;
    chk("R11", "lookup alongside fill sees old", int'(resp_hit_o), 0);
    expect_hit("R11", 8'h21, 6'h30, 3'd6);
  endtask

  task automatic t_flush;
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    expect_miss("R9", 8'h0F);
    expect_miss("R9", 8'h10);
    expect_miss("R9", 8'h21);
  endtask

  task automatic t_flush_fill;
    @(negedge clk_i);
    flush_i = 1'b1;
    fill_i = 1'b1; fill_vpn_i = 8'h25; fill_ppn_i = 6'h31; fill_perm_i = 3'd7;
    @(negedge clk_i);
    flush_i = 1'b0; fill_i = 1'b0;
    expect_miss("R10", 8'h25);
    fill(8'h25, 6'h31, 3'd7);
    expect_hit("R10", 8'h25, 6'h31, 3'd7);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_latency();
    t_basic();
    t_fill_free();
    t_evict();
    t_refresh();
    t_same_cycle();
    t_flush();
    t_flush_fill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule